// File: doc/BRIEF.md
# Chip Timing Tracker with Symbol Strobe Selection

This block keeps a spread-spectrum receiver's chip sampling aligned with the incoming chips. It receives one sign bit per de-rotated baseband sample together with a valid flag. Valid samples are dealt alternately to an on-time stream and a transition stream. The on-time samples are the ones a correlator would use. The transition samples sit on chip boundaries when timing is correct. Whenever the two on-time signs on either side of a transition sample differ, a chip boundary has been seen and a ternary timing error is produced. Its polarity is set by whether the transition sample agrees with the on-time sample that follows it.

The errors are summed in a saturating signed accumulator over a window of symbols. At the close of each window the accumulator is compared against a symmetric threshold and the sampling phase is moved one eighth of a chip earlier or later. The phase index has three bits. Bit 0 picks the sample-clock edge and bits 2:1 pick the pulse slot within a chip. A carry or borrow out of the edge bit moves the symbol strobe by one whole sample-clock pulse, so the symbol period after that decision becomes one pulse shorter or longer. The symbol strobe is otherwise one pulse out of every PER sample-clock cycles. The reset is asynchronous on assertion and is released through a two-stage synchronizer.

Top module: `chip_timing_tracker`

## Requirements
- R1: While reset is asserted, and after its release, `sym_stb_o`, `adj_o`, `adj_dir_o` and `phase_o` are zero. The first `sym_stb_o` appears PER+1 rising edges after `rst_n` rises: two edges for reset synchronization, then PER-1 counting edges.
- R2: Only cycles with `smp_vld` high carry samples, and the sign on other cycles is ignored. After reset the first valid sample is on-time, and valid samples then alternate between the on-time and transition roles.
- R3: Sign bit 1 means negative. When an on-time sample follows a transition sample that itself followed an earlier on-time sample, an error is formed. It is +1 if the bracketing on-time signs differ and the transition sign equals the new on-time sign. It is -1 if they differ and the signs do not match. It is 0 if the bracketing signs are equal. No other sample produces an error.
- R4: With no correction pending, `sym_stb_o` is a single-cycle pulse every PER cycles.
- R5: On the strobe that closes every WIN-th symbol with `en` high, the decision is taken. If the accumulator is above +THR the block advances. If it is below -THR the block retards. Otherwise nothing happens. The accumulator then restarts from that cycle's error. `adj_o` pulses for one cycle on the cycle after that strobe, with `adj_dir_o` = 1 for advance and 0 for retard.
- R6: The accumulator saturates at +/-(2^(ACC_W-1)-1) instead of wrapping.
- R7: An advance adds 1 to `phase_o` modulo 8 and a retard subtracts 1 modulo 8. `phase_o` changes only in the cycle in which `adj_o` is high.
- R8: The symbol period that follows a decision is PER-1 cycles if the decision advanced from an odd phase. It is PER+1 cycles if the decision retarded from an even phase. In all other cases it is PER cycles. This includes the wraps 7 to 0 and 0 to 7.
- R9: While `en` is low, errors are not accumulated, the accumulator and `phase_o` hold, and no decision is taken. The strobe and sample routing continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Tracking enable |
| smp_vld | input | 1 | Sample present this cycle |
| smp_sgn | input | 1 | Sign of the de-rotated sample (1 = negative) |
| sym_stb_o | output | 1 | One-cycle symbol strobe |
| phase_o | output | 3 | Eighth-chip phase index (bit 0 edge, bits 2:1 pulse slot) |
| adj_o | output | 1 | One-cycle pulse after a phase step |
| adj_dir_o | output | 1 | Direction of the step (1 advance, 0 retard) |

## Verification
The hardest situation to reach from the ports is an accumulator that holds exactly THR or THR+1 at the close of a window. Errors only form from a three-sample on-time/transition/on-time pattern, and the window boundary is roughly a thousand cycles away. The bench tracks the role of the next sample from its own model. It first inserts a neutral on-time sample when needed, then feeds a counted number of transition/on-time pairs right after a window boundary and stays idle until the boundary closes. Saturation is reached by a full-rate biased stream that would wrap an unsaturated accumulator to the opposite sign. Enable hold is shown by taking `en` low across one boundary and seeing the held count cause a step one window later.

// File: rtl/chip_tt_pkg.sv
package chip_tt_pkg;

  // Phase-step command produced at the end of a tracking window.
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_ADV  = 2'd1,
    STEP_RET  = 2'd2
  } step_e;

  // Eighth-chip phase index width (edge select + two pulse-slot bits).
  localparam int PH_W = 3;

endpackage

// File: rtl/chip_tt_split.sv
// Deals valid samples into on-time / transition roles and forms the
// ternary chip-phase error when an on-time sample closes a bracket.
module chip_tt_split (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic              smp_sgn,
  output logic signed [1:0] err
);

  logic is_mid_q, is_mid_d;
  logic have_end_q, have_end_d;
  logic mid_pend_q, mid_pend_d;
  logic end_q, end_d;
  logic mid_q, mid_d;

  always_comb begin
    is_mid_d   = is_mid_q;
    have_end_d = have_end_q;
    mid_pend_d = mid_pend_q;
    end_d      = end_q;
    mid_d      = mid_q;
    err        = 2'sd0;
    if (smp_vld) begin
      is_mid_d = ~is_mid_q;
      if (!is_mid_q) begin
        // on-time slot: close any open bracket
        if (mid_pend_q && (end_q != smp_sgn)) begin
          err = (mid_q == smp_sgn) ? 2'sd1 : -2'sd1;
        end
        end_d      = smp_sgn;
        have_end_d = 1'b1;
        mid_pend_d = 1'b0;
      end else begin
        // transition slot: open a bracket if an on-time sample precedes it
        mid_d      = smp_sgn;
        mid_pend_d = have_end_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_mid_q   <= 1'b0;
      have_end_q <= 1'b0;
      mid_pend_q <= 1'b0;
      end_q      <= 1'b0;
      mid_q      <= 1'b0;
    end else begin
      is_mid_q   <= is_mid_d;
      have_end_q <= have_end_d;
      mid_pend_q <= mid_pend_d;
      end_q      <= end_d;
      mid_q      <= mid_d;
    end
  end

  AST_ROLE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> (is_mid_q != $past(is_mid_q))); // R2

  AST_ERR_ONLY_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (err != 2'sd0) |-> (smp_vld && !is_mid_q && mid_pend_q)); // R3

endmodule

// File: rtl/chip_tt_acc.sv
// Saturating window accumulator and threshold decision.
module chip_tt_acc
  import chip_tt_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int THR   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic signed [1:0] err,
  input  logic              win_end,
  output step_e             step
);

  localparam logic signed [ACC_W:0]   SAT_HI = (ACC_W+1)'(2**(ACC_W-1) - 1);
  localparam logic signed [ACC_W:0]   SAT_LO = -SAT_HI;
  localparam logic signed [ACC_W-1:0] THR_P  = ACC_W'(THR);
  localparam logic signed [ACC_W-1:0] THR_N  = -THR_P;
  localparam logic [ACC_W-1:0]        MOST_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W:0]   sum;

  always_comb begin
    sum   = {acc_q[ACC_W-1], acc_q} + {{(ACC_W-1){err[1]}}, err};
    acc_d = acc_q;
    if (en) begin
      if (win_end) begin
        acc_d = {{(ACC_W-2){err[1]}}, err};
      end else if (sum > SAT_HI) begin
        acc_d = SAT_HI[ACC_W-1:0];
      end else if (sum < SAT_LO) begin
        acc_d = SAT_LO[ACC_W-1:0];
      end else begin
        acc_d = sum[ACC_W-1:0];
      end
    end
  end

  always_comb begin
    step = STEP_NONE;
    if (win_end && en) begin
      if (acc_q > THR_P)      step = STEP_ADV;
      else if (acc_q < THR_N) step = STEP_RET;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_ACC_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q != MOST_NEG); // R6

  AST_ACC_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q)); // R9

  AST_STEP_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step != STEP_NONE) |-> (win_end && en)); // R5

endmodule

// File: rtl/chip_tt_timebase.sv
// Symbol strobe counter, window counter and eighth-chip phase index.
module chip_tt_timebase
  import chip_tt_pkg::*;
#(
  parameter int PER = 32,
  parameter int WIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  step_e           step,
  output logic            sym_stb,
  output logic            win_end,
  output logic [PH_W-1:0] phase,
  output logic            adj,
  output logic            adj_dir
);

  localparam int CNT_W = $clog2(PER + 1);
  localparam int SYM_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CNT_W-1:0] RLD_NORM  = CNT_W'(PER - 1);
  localparam logic [CNT_W-1:0] RLD_SHORT = CNT_W'(PER - 2);
  localparam logic [CNT_W-1:0] RLD_LONG  = CNT_W'(PER);
  localparam logic [SYM_W-1:0] SYM_LAST  = SYM_W'(WIN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SYM_W-1:0] sym_q, sym_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             adj_q, adj_d;
  logic             dir_q, dir_d;
  step_e            step_eff;

  assign sym_stb = (cnt_q == '0);
  assign win_end = sym_stb && (sym_q == SYM_LAST);

  always_comb begin
    step_eff = win_end ? step : STEP_NONE;
    cnt_d    = cnt_q - 1'b1;
    sym_d    = sym_q;
    ph_d     = ph_q;
    adj_d    = 1'b0;
    dir_d    = dir_q;
    if (sym_stb) begin
      cnt_d = RLD_NORM;
      sym_d = (sym_q == SYM_LAST) ? '0 : sym_q + 1'b1;
    end
    case (step_eff)
      STEP_ADV: begin
        // carry out of the edge bit: strobe moves one pulse earlier
        if (ph_q[0]) cnt_d = RLD_SHORT;
        ph_d  = ph_q + 1'b1;
        adj_d = 1'b1;
        dir_d = 1'b1;
      end
      STEP_RET: begin
        // borrow out of the edge bit: strobe moves one pulse later
        if (!ph_q[0]) cnt_d = RLD_LONG;
        ph_d  = ph_q - 1'b1;
        adj_d = 1'b1;
        dir_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RLD_NORM;
      sym_q <= '0;
      ph_q  <= '0;
      adj_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sym_q <= sym_d;
      ph_q  <= ph_d;
      adj_q <= adj_d;
      dir_q <= dir_d;
    end
  end

  assign phase   = ph_q;
  assign adj     = adj_q;
  assign adj_dir = dir_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> !sym_stb); // R4

  AST_ADJ_FOLLOWS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    adj |-> $past(win_end)); // R5

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (adj && adj_dir) |-> (phase == $past(phase) + 1'b1)); // R7

  AST_PHASE_RETARD: assert property (@(posedge clk) disable iff (!rst_n)
    (adj && !adj_dir) |-> (phase == $past(phase) - 1'b1)); // R7

  AST_PHASE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !adj |-> $stable(phase)); // R7

endmodule

// File: rtl/chip_timing_tracker.sv
module chip_timing_tracker
  import chip_tt_pkg::*;
#(
  parameter int PER   = 32,
  parameter int WIN   = 32,
  parameter int ACC_W = 8,
  parameter int THR   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            smp_vld,
  input  logic            smp_sgn,
  output logic            sym_stb_o,
  output logic [PH_W-1:0] phase_o,
  output logic            adj_o,
  output logic            adj_dir_o
);

  logic              rst_meta_q, rst_sync_q;
  logic signed [1:0] err;
  logic              win_end;
  step_e             step;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  chip_tt_split u_split (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .smp_vld (smp_vld),
    .smp_sgn (smp_sgn),
    .err     (err)
  );

  chip_tt_acc #(
    .ACC_W (ACC_W),
    .THR   (THR)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .en      (en),
    .err     (err),
    .win_end (win_end),
    .step    (step)
  );

  chip_tt_timebase #(
    .PER (PER),
    .WIN (WIN)
  ) u_tb (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .step    (step),
    .sym_stb (sym_stb_o),
    .win_end (win_end),
    .phase   (phase_o),
    .adj     (adj_o),
    .adj_dir (adj_dir_o)
  );

  AST_ADJ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    adj_o |=> !adj_o); // R5

  AST_NO_STEP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !en |=> !adj_o); // R9

endmodule

// File: tb/chip_timing_tracker_test.sv
`timescale 1ns/1ps
module chip_timing_tracker_test;

  localparam int PER   = 32;
  localparam int WIN   = 32;
  localparam int ACC_W = 8;
  localparam int THR   = 4;
  localparam int SAT   = 2**(ACC_W-1) - 1;
  localparam int BODY  = WIN*PER - 40;

  logic       clk = 1'b0;
  logic       rst_n, en, smp_vld, smp_sgn;
  logic       sym_stb_o, adj_o, adj_dir_o;
  logic [2:0] phase_o;

  always #2 clk = ~clk;

  chip_timing_tracker #(.PER(PER), .WIN(WIN), .ACC_W(ACC_W), .THR(THR)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_vld(smp_vld), .smp_sgn(smp_sgn),
    .sym_stb_o(sym_stb_o), .phase_o(phase_o), .adj_o(adj_o), .adj_dir_o(adj_dir_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_sync, m_left, m_sym, m_acc, m_phase, m_nv;
  bit m_adj, m_dir, m_end, m_mid, m_have_end, m_mid_ok;

  task automatic model_reset();
    m_left = PER - 1; m_sym = 0; m_acc = 0; m_phase = 0; m_nv = 0;
    m_adj = 0; m_dir = 0; m_end = 0; m_mid = 0; m_have_end = 0; m_mid_ok = 0;
  endtask

  task automatic model_step();
    int e, stp, sum;
    bit stb, win;
    stb = (m_left == 0);
    win = stb && (m_sym == WIN - 1);
    e = 0;
    if (smp_vld) begin
      if (m_nv % 2 == 0) begin
        if (m_mid_ok && (m_end != smp_sgn)) e = (m_mid == smp_sgn) ? 1 : -1;
        m_end = smp_sgn; m_have_end = 1; m_mid_ok = 0;
      end else begin
        m_mid = smp_sgn; m_mid_ok = m_have_end;
      end
      m_nv++;
    end
    stp = 0;
    if (win && en) begin
      if (m_acc > THR) stp = 1;
      else if (m_acc < -THR) stp = -1;
    end
    if (en) begin
      if (win) m_acc = e;
      else begin
        sum = m_acc + e;
        m_acc = (sum > SAT) ? SAT : ((sum < -SAT) ? -SAT : sum);
      end
    end
    if (stb) begin
      m_left = PER - 1;
      if (stp == 1 && (m_phase % 2 == 1)) m_left = PER - 2;
      if (stp == -1 && (m_phase % 2 == 0)) m_left = PER;
      m_sym = (m_sym == WIN - 1) ? 0 : m_sym + 1;
    end else begin
      m_left--;
    end
    m_phase = (m_phase + stp + 8) % 8;
    m_adj = (stp != 0);
    if (stp != 0) m_dir = (stp == 1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; model_reset();
    end else if (m_sync < 2) begin
      m_sync++; model_reset();
    end else begin
      model_step();
    end
  end

  // ---------------- per-cycle comparison and port monitors ----------------
  int n_adv = 0, n_ret = 0, gap = 0, pend_mod = 0;
  bit seen_stb = 0;

  always @(negedge clk) begin
    if (rst_n && m_sync == 2) begin
      check(sym_stb_o == (m_left == 0), "R4 strobe", sym_stb_o, m_left == 0);
      check(phase_o == m_phase[2:0], "R7 phase", phase_o, m_phase);
      check(adj_o == m_adj, "R5 adjust pulse", adj_o, m_adj);
      if (adj_o) check(adj_dir_o == m_dir, "R7 adjust direction", adj_dir_o, m_dir);
      gap++;
      if (adj_o) begin
        if (adj_dir_o) n_adv++; else n_ret++;
        if (adj_dir_o && !phase_o[0]) pend_mod = -1;
        else if (!adj_dir_o && phase_o[0]) pend_mod = 1;
      end
      if (sym_stb_o) begin
        if (seen_stb) check(gap == PER + pend_mod, "R8 symbol period", gap, PER + pend_mod);
        pend_mod = 0; gap = 0; seen_stb = 1;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(bit v, bit s, bit e);
    smp_vld = v; smp_sgn = s; en = e;
    @(negedge clk);
  endtask

  // mode +1: biased towards advance, -1: towards retard, 0: no transitions, 2: random
  function automatic bit gen(int mode);
    bit is_end = (m_nv % 2 == 0);
    case (mode)
      1:       return is_end ? m_mid : ~m_end;
      -1:      return is_end ? ~m_end : m_end;
      0:       return m_end;
      default: return 1'($urandom);
    endcase
  endfunction

  task automatic settle(bit e);
    smp_vld = 0; en = e;
    while (!(sym_stb_o && (m_sym == WIN - 1))) @(negedge clk);
    drive(0, 0, e);
    drive(0, 0, e);
  endtask

  task automatic win_run(int mode, int period, bit e);
    for (int i = 0; i < BODY; i++) begin
      bit v = (i % period == 0);
      drive(v, v ? gen(mode) : 1'($urandom), (mode == 3) ? 1'($urandom) : e);
    end
    settle(e);
  endtask

  task automatic pairs(int n, int mode, bit e);
    if (m_nv % 2 == 0) drive(1, m_end, e);
    for (int i = 0; i < n; i++) begin
      drive(1, gen(mode), e);
      drive(1, gen(mode), e);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 200000 cycles expected completion earlier");
    finish_up();
  end

  initial begin
    int a0, r0, k;
    rst_n = 0; en = 0; smp_vld = 0; smp_sgn = 0;
    repeat (5) @(negedge clk);
    check(sym_stb_o == 0 && adj_o == 0 && adj_dir_o == 0, "R1 outputs in reset", sym_stb_o | adj_o, 0);
    check(phase_o == 0, "R1 phase in reset", phase_o, 0);
    rst_n = 1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!sym_stb_o && k < 200);
    check(k == PER + 1, "R1 first strobe delay", k, PER + 1);
    settle(1);
    check(phase_o == 0, "R1 phase after first window", phase_o, 0);

    // no transitions: no error, no step
    a0 = n_adv; r0 = n_ret;
    win_run(0, 1, 1); win_run(0, 1, 1);
    check((n_adv - a0) + (n_ret - r0) == 0, "R3 no steps without transitions", (n_adv - a0) + (n_ret - r0), 0);

    // full-rate advance: about 490 errors per window must saturate, not wrap
    a0 = n_adv;
    repeat (3) win_run(1, 1, 1);
    check(n_adv - a0 == 3, "R6 saturated advance steps", n_adv - a0, 3);
    check(phase_o == 3, "R7 phase after three advances", phase_o, 3);

    // full-rate retard through the 0 -> 7 wrap
    r0 = n_ret;
    repeat (5) win_run(-1, 1, 1);
    check(n_ret - r0 == 5, "R3 retard steps from negative errors", n_ret - r0, 5);
    check(phase_o == 6, "R7 phase after retard wrap", phase_o, 6);

    // threshold boundaries
    a0 = n_adv; r0 = n_ret;
    pairs(THR, 1, 1); settle(1);
    check((n_adv - a0) + (n_ret - r0) == 0, "R5 count equal to +THR holds", (n_adv - a0) + (n_ret - r0), 0);
    a0 = n_adv;
    pairs(THR + 1, 1, 1); settle(1);
    check(n_adv - a0 == 1, "R5 count THR+1 advances", n_adv - a0, 1);
    r0 = n_ret; a0 = n_adv;
    pairs(THR, -1, 1); settle(1);
    check((n_ret - r0) + (n_adv - a0) == 0, "R5 count equal to -THR holds", (n_ret - r0) + (n_adv - a0), 0);
    r0 = n_ret;
    pairs(THR + 1, -1, 1); settle(1);
    check(n_ret - r0 == 1, "R5 count -(THR+1) retards", n_ret - r0, 1);

    // sparse samples with junk signs on idle cycles
    a0 = n_adv;
    win_run(1, 3, 1);
    check(n_adv - a0 == 1, "R2 sparse samples still advance", n_adv - a0, 1);

    // enable low across a boundary holds the accumulator
    a0 = n_adv; k = phase_o;
    pairs(THR + 1, 1, 1);
    en = 0;
    settle(0);
    check(n_adv - a0 == 0, "R9 no step while disabled", n_adv - a0, 0);
    check(phase_o == k[2:0], "R9 phase held while disabled", phase_o, k);
    settle(1);
    check(n_adv - a0 == 1, "R9 held count steps once enabled", n_adv - a0, 1);

    // random streams, including random enable
    win_run(2, 1, 1);
    win_run(2, 2, 1);
    win_run(3, 1, 1);

    finish_up();
  end

endmodule